// File: doc/BRIEF.md
# ISA Bus Strobe Direction and Low-Memory Strobe Steering

This block sits between a system controller's internal bus agents and the ISA bus pads. On every bus clock it works out who owns the bus: the CPU (idle), the DMA engine, the refresh logic, or an external ISA bus master. From that owner it decides four things for each of the bidirectional command strobes (memory read, memory write, I/O read and I/O write):

- whether the chip drives the strobe;
- the level it drives;
- the level of the address-enable output;
- the two always-driven low-memory strobes, which are used by cards that decode only the first megabyte.

The DMA engine and the refresh logic supply their own internal strobe levels. The pad receivers supply the strobe levels currently on the bus. The top four address bits gate the low-memory strobes. While the refresh pin is low, the read strobe bypasses that gate, so refresh reaches every memory card. All outputs are registered on the bus clock, so each one reflects the inputs sampled at the previous rising edge.

Top module: `isa_strobe_steer`

## Requirements
- R1: `aen_o` is 1 in the cycle after `dma_act_i`=1 with `master_n_i`=1 and `rfsh_act_i`=0 were sampled. It is 0 after any other input combination.
- R2: While `master_n_i`=0 is sampled and refresh is not active, `aen_o` is 0 and all four output enables are 0.
- R3: In DMA ownership (`dma_act_i`=1, `master_n_i`=1, `rfsh_act_i`=0), all four enables are 1. Each driven value equals the matching internal strobe.
- R4: While `rfsh_act_i`=1 is sampled, whatever the state of `master_n_i`, the memory-read enable is 1 and drives the internal memory-read strobe. The memory-write, I/O-read and I/O-write enables are 0.
- R5: Whenever a strobe's enable is 0, its driven value is 1.
- R6: The memory-read bus level is the driven value when that strobe is enabled and the pad input otherwise. The memory-write bus level is formed the same way.
  - When `addr_hi_i` (bits A23..A20, bit 0 = A20) is all zero, `smemr_n_o` and `smemw_n_o` follow these two levels in every ownership mode.
  - When any bit of `addr_hi_i` is set, both are 1.
- R7: While `rfsh_pin_n_i`=0 is sampled, `smemr_n_o` follows the memory-read bus level whatever `addr_hi_i` holds. `smemw_n_o` keeps the R6 rule.
- R8: Every output changes only at a rising clock edge and reflects the inputs of the previous edge. When `rst_n`=0 is sampled, the next state is: all enables 0, all driven values 1, `aen_o`=0, and `smemr_n_o`=`smemw_n_o`=1.
- R9: `dma_act_i` and `rfsh_act_i` are never 1 together. If they are, refresh owns the memory-read strobe and the overlap is flagged as a protocol error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_act_i | input | 1 | DMA cycle in progress |
| rfsh_act_i | input | 1 | Refresh cycle in progress (internal or master-started) |
| rfsh_pin_n_i | input | 1 | Level of the active-low refresh pin |
| master_n_i | input | 1 | Active-low external bus master grant |
| int_strb_n_i | input | 4 | Internal strobe levels: [0] mem read, [1] mem write, [2] I/O read, [3] I/O write |
| pad_strb_n_i | input | 4 | Strobe levels received from the pads, same order |
| addr_hi_i | input | 4 | Address bits A23..A20, bit 0 = A20 |
| aen_o | output | 1 | Address enable |
| strb_oe_o | output | 4 | Per-strobe output enable, same order |
| strb_drv_n_o | output | 4 | Per-strobe driven level, same order |
| smemr_n_o | output | 1 | Low-megabyte memory read strobe |
| smemw_n_o | output | 1 | Low-megabyte memory write strobe |

## Verification
The bench concentrates on the transitions where a wrong answer would be silent on a real bus.

- **External master with refresh.** A design that lets the master grant override refresh would release memory-read during a refresh the master itself started, and that refresh would never happen.
- **Address gate while the refresh pin is low.** A design that applies the gate to both strobes during refresh would let memory-write leak past the one-megabyte boundary. A design that never bypasses the gate would miss refresh on low-memory cards whenever the upper address bits are non-zero.
- **Low-memory strobes in undriven modes.** These modes must track the pad levels rather than the internal ones. A wrong source would echo stale internal strobes onto the low-memory bus while a master runs cycles.
- **Address enable under DMA with the master grant low.** A design that raises it here would float I/O decoders during master cycles.

// File: rtl/isa_steer_pkg.sv
// Package: shared types and strobe indices for the ISA strobe steering block.
// Assumes strobe vectors are ordered mem-read, mem-write, io-read, io-write.
package isa_steer_pkg;
    localparam int NUM_STRB  = 4;
    localparam int STRB_MEMR = 0;
    localparam int STRB_MEMW = 1;
    localparam int STRB_IOR  = 2;
    localparam int STRB_IOW  = 3;

    typedef enum logic [1:0] {
        OWN_CPU     = 2'd0,
        OWN_DMA     = 2'd1,
        OWN_REFRESH = 2'd2,
        OWN_XMASTER = 2'd3
    } bus_owner_e;
endpackage

// File: rtl/isa_owner_decode.sv
// Module: isa_owner_decode
// Picks the current bus owner from the activity inputs. Priority is
// refresh, then external master, then DMA, then CPU/idle. Purely combinational.
module isa_owner_decode
    import isa_steer_pkg::*;
(
    input  logic       dma_act_i,
    input  logic       rfsh_act_i,
    input  logic       master_n_i,
    output bus_owner_e owner_o
);
    // Priority select of bus owner
    always_comb begin
        if (rfsh_act_i)       owner_o = OWN_REFRESH;
        else if (!master_n_i) owner_o = OWN_XMASTER;
        else if (dma_act_i)   owner_o = OWN_DMA;
        else                  owner_o = OWN_CPU;
    end
endmodule

// File: rtl/isa_strobe_dir.sv
// Module: isa_strobe_dir
// Per-strobe direction control. It produces the next enable, the driven
// value (inactive high when not enabled) and the resolved bus level
// (driven value if enabled, otherwise the pad value). Combinational.
module isa_strobe_dir
    import isa_steer_pkg::*;
#(
    parameter int N = NUM_STRB
) (
    input  bus_owner_e   owner_i,
    input  logic [N-1:0] int_n_i,
    input  logic [N-1:0] pad_n_i,
    output logic [N-1:0] oe_o,
    output logic [N-1:0] drv_n_o,
    output logic [N-1:0] bus_n_o
);
    logic [N-1:0] en_mask;

    // Enable mask per ownership mode
    always_comb begin
        en_mask = '0;
        unique case (owner_i)
            OWN_DMA:     en_mask = '1;
            OWN_REFRESH: en_mask[STRB_MEMR] = 1'b1;
            default:     en_mask = '0;
        endcase
    end

    // One output mux pair per strobe
    for (genvar g = 0; g < N; g++) begin : g_strb
        assign oe_o[g]    = en_mask[g];
        assign drv_n_o[g] = en_mask[g] ? int_n_i[g] : 1'b1;
        assign bus_n_o[g] = en_mask[g] ? int_n_i[g] : pad_n_i[g];
    end
endmodule

// File: rtl/isa_lowmem_gate.sv
// Module: isa_lowmem_gate
// Derives the low-megabyte memory strobes. Both are gated by the upper
// address bits. The read strobe bypasses the gate while the refresh pin is low.
module isa_lowmem_gate #(
    parameter int HI_W = 4
) (
    input  logic            memr_bus_n_i,
    input  logic            memw_bus_n_i,
    input  logic [HI_W-1:0] addr_hi_i,
    input  logic            rfsh_pin_n_i,
    output logic            smemr_n_o,
    output logic            smemw_n_o
);
    logic below_1m;

    // Address gate and refresh bypass
    always_comb begin
        below_1m  = (addr_hi_i == '0);
        smemr_n_o = (below_1m || !rfsh_pin_n_i) ? memr_bus_n_i : 1'b1;
        smemw_n_o = below_1m ? memw_bus_n_i : 1'b1;
    end
endmodule

// File: rtl/isa_strobe_steer.sv
// Module: isa_strobe_steer (top)
// Registers the ISA address enable, strobe direction, driven levels and
// low-memory strobes on the bus clock. Assumes all inputs are synchronous
// to clk, and that DMA and refresh activity never overlap.
module isa_strobe_steer
    import isa_steer_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dma_act_i,
    input  logic                rfsh_act_i,
    input  logic                rfsh_pin_n_i,
    input  logic                master_n_i,
    input  logic [NUM_STRB-1:0] int_strb_n_i,
    input  logic [NUM_STRB-1:0] pad_strb_n_i,
    input  logic [HI_W-1:0]     addr_hi_i,
    output logic                aen_o,
    output logic [NUM_STRB-1:0] strb_oe_o,
    output logic [NUM_STRB-1:0] strb_drv_n_o,
    output logic                smemr_n_o,
    output logic                smemw_n_o
);
    bus_owner_e          owner;
    logic [NUM_STRB-1:0] oe_nx, drv_nx, bus_nx;
    logic                smemr_nx, smemw_nx;

    isa_owner_decode u_dec (
        .dma_act_i  (dma_act_i),
        .rfsh_act_i (rfsh_act_i),
        .master_n_i (master_n_i),
        .owner_o    (owner)
    );

    isa_strobe_dir #(.N(NUM_STRB)) u_dir (
        .owner_i (owner),
        .int_n_i (int_strb_n_i),
        .pad_n_i (pad_strb_n_i),
        .oe_o    (oe_nx),
        .drv_n_o (drv_nx),
        .bus_n_o (bus_nx)
    );

    isa_lowmem_gate #(.HI_W(HI_W)) u_low (
        .memr_bus_n_i (bus_nx[STRB_MEMR]),
        .memw_bus_n_i (bus_nx[STRB_MEMW]),
        .addr_hi_i    (addr_hi_i),
        .rfsh_pin_n_i (rfsh_pin_n_i),
        .smemr_n_o    (smemr_nx),
        .smemw_n_o    (smemw_nx)
    );

    // Output register stage with synchronous reset to the safe input state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aen_o        <= 1'b0;
            strb_oe_o    <= '0;
            strb_drv_n_o <= '1;
            smemr_n_o    <= 1'b1;
            smemw_n_o    <= 1'b1;
        end else begin
            aen_o        <= (owner == OWN_DMA);
            strb_oe_o    <= oe_nx;
            strb_drv_n_o <= drv_nx;
            smemr_n_o    <= smemr_nx;
            smemw_n_o    <= smemw_nx;
        end
    end

    // Address enable only after a DMA cycle with no master grant
    assert_aen_dma_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        aen_o |-> ($past(dma_act_i) && $past(master_n_i)));

    // Master grant without refresh releases every strobe and AEN
    assert_master_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_n_i && !rfsh_act_i) |=> (!aen_o && strb_oe_o == '0));

    // Refresh drives only the memory-read strobe
    assert_rfsh_memr_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_act_i |=> (strb_oe_o == 4'b0001));

    // An undriven strobe reads inactive high
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_drv_n_o | strb_oe_o) == '1));

    // Upper address without the refresh pin low blocks both low-memory strobes
    assert_above_1m_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_hi_i != '0) && rfsh_pin_n_i) |=> (smemr_n_o && smemw_n_o));

    // Reset leaves the block in the input state
    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (!aen_o && strb_oe_o == '0 && smemr_n_o && smemw_n_o));

    // DMA and refresh must never overlap
    assert_no_dma_rfsh_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_act_i && rfsh_act_i));
endmodule

// File: tb/isa_strobe_steer_tb_top.sv
// Bench: behavioural next-state model, compared at every falling edge.
module isa_strobe_steer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dma_act_i, rfsh_act_i, rfsh_pin_n_i, master_n_i;
    logic [3:0] int_strb_n_i, pad_strb_n_i, addr_hi_i;
    logic       aen_o, smemr_n_o, smemw_n_o;
    logic [3:0] strb_oe_o, strb_drv_n_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // expected next outputs
    logic       e_aen, e_smemr, e_smemw;
    logic [3:0] e_oe, e_drv;

    always #5 clk = ~clk;

    isa_strobe_steer dut_i (
        .clk(clk), .rst_n(rst_n), .dma_act_i(dma_act_i), .rfsh_act_i(rfsh_act_i),
        .rfsh_pin_n_i(rfsh_pin_n_i), .master_n_i(master_n_i),
        .int_strb_n_i(int_strb_n_i), .pad_strb_n_i(pad_strb_n_i),
        .addr_hi_i(addr_hi_i), .aen_o(aen_o), .strb_oe_o(strb_oe_o),
        .strb_drv_n_o(strb_drv_n_o), .smemr_n_o(smemr_n_o), .smemw_n_o(smemw_n_o)
    );

    task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model of what the outputs should become after the current inputs
    task automatic predict();
        logic memr_lvl, memw_lvl;
        if (!rst_n) begin
            e_aen = 0; e_oe = 4'b0000; e_drv = 4'b1111; e_smemr = 1; e_smemw = 1;
            return;
        end
        e_aen = 0; e_oe = 4'b0000;
        if (rfsh_act_i) e_oe = 4'b0001;
        else if (master_n_i && dma_act_i) begin e_oe = 4'b1111; e_aen = 1; end
        for (int i = 0; i < 4; i++) e_drv[i] = e_oe[i] ? int_strb_n_i[i] : 1'b1;
        memr_lvl = e_oe[0] ? int_strb_n_i[0] : pad_strb_n_i[0];
        memw_lvl = e_oe[1] ? int_strb_n_i[1] : pad_strb_n_i[1];
        e_smemw = 1; e_smemr = 1;
        if (addr_hi_i == 4'h0) begin e_smemr = memr_lvl; e_smemw = memw_lvl; end
        if (!rfsh_pin_n_i) e_smemr = memr_lvl;
    endtask

    task automatic compare(string tag);
        chk("R1", {tag, " aen"}, {3'b0, aen_o}, {3'b0, e_aen});
        chk(rfsh_act_q ? "R4" : (!master_q ? "R2" : "R3"), {tag, " oe"}, strb_oe_o, e_oe);
        chk("R5", {tag, " drv"}, strb_drv_n_o, e_drv);
        chk("R6", {tag, " smemw"}, {3'b0, smemw_n_o}, {3'b0, e_smemw});
        chk(rfsh_pin_q ? "R6" : "R7", {tag, " smemr"}, {3'b0, smemr_n_o}, {3'b0, e_smemr});
    endtask

    logic rfsh_act_q, master_q, rfsh_pin_q;

    // mode 0 cpu, 1 dma, 2 refresh, 3 master, 4 master+refresh, 5 dma with master low
    task automatic drive_mode(int mode);
        dma_act_i  = (mode == 1 || mode == 5);
        rfsh_act_i = (mode == 2 || mode == 4);
        master_n_i = !(mode == 3 || mode == 4 || mode == 5);
        rfsh_pin_n_i = rfsh_act_i ? $urandom_range(0, 3) != 0 ? 1'b0 : 1'b1
                                  : ($urandom_range(0, 3) != 0);
        int_strb_n_i = 4'($urandom);
        pad_strb_n_i = 4'($urandom);
        addr_hi_i    = ($urandom_range(0, 1) != 0) ? 4'h0 : 4'($urandom);
    endtask

    // one cycle: drive at falling edge, check at next falling edge (R8 latency)
    task automatic step(int mode, string tag);
        drive_mode(mode);
        predict();
        rfsh_act_q = rfsh_act_i; master_q = master_n_i; rfsh_pin_q = rfsh_pin_n_i;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst_n = 0; dma_act_i = 0; rfsh_act_i = 0; rfsh_pin_n_i = 1; master_n_i = 1;
        int_strb_n_i = 4'hF; pad_strb_n_i = 4'hF; addr_hi_i = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", "reset aen", {3'b0, aen_o}, 4'b0);
        chk("R8", "reset oe", strb_oe_o, 4'b0000);
        chk("R8", "reset drv", strb_drv_n_o, 4'b1111);
        chk("R8", "reset smem", {2'b0, smemr_n_o, smemw_n_o}, 4'b0011);
        rst_n = 1;
        for (int m = 0; m < 6; m++)
            for (int k = 0; k < 150; k++) step(m, $sformatf("mode%0d", m));
        for (int k = 0; k < 2000; k++) step($urandom_range(0, 5), "mixed");
        // R7 directed: refresh pin low, upper address set, master-started refresh
        master_n_i = 0; rfsh_act_i = 1; dma_act_i = 0; rfsh_pin_n_i = 0;
        addr_hi_i = 4'h8; int_strb_n_i = 4'b1110; pad_strb_n_i = 4'b1101;
        predict(); rfsh_act_q = 1; master_q = 0; rfsh_pin_q = 0;
        @(negedge clk);
        chk("R7", "bypass smemr", {3'b0, smemr_n_o}, 4'b0000);
        chk("R7", "smemw gated", {3'b0, smemw_n_o}, 4'b0001);
        compare("directed");
        // R8 mid-run reset from DMA
        rfsh_act_i = 0; master_n_i = 1; dma_act_i = 1; int_strb_n_i = 4'h0;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R8", "rerun reset oe", strb_oe_o, 4'b0000);
        chk("R8", "rerun reset aen", {3'b0, aen_o}, 4'b0);
        chk("R8", "rerun reset drv", strb_drv_n_o, 4'b1111);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule